// File: doc/BRIEF.md
# Machine Security Configuration Register

This block holds the three machine-level control bits that steer a physical memory protection (PMP) unit: a lockdown bit that changes how rule lock bits are read, an allowlist bit that makes unmatched machine-mode accesses fail, and a bypass bit that allows locked rules to be edited. Software reaches the bits through a CSR port. The block sends them continuously to the protection checker and to the filter that guards PMP configuration writes.

Whether the lockdown and allowlist bits are tied to 0, tied to 1, or set-only is chosen per bit when the block is built. A build switch decides whether the bypass bit can be written at all. The PMP unit reports whether any of its entries carries a lock bit; enabled and disabled entries both count. While the bypass bit is clear and such a lock exists, the bypass bit is frozen. A dedicated PMP reset input restores every field to its build-time reset value and lifts the freeze.

On 32-bit harts a second CSR address covers the upper half of the register. Privilege checking of the CSR access is left to the surrounding CSR file.

Top module: `sec_cfg_csr`

## Requirements
- R1: At address 0x747 the read data carries the lockdown bit at bit 0, the allowlist bit at bit 1 and the bypass bit at bit 2. Reads are combinational. A write with `csr_we_i` high changes the stored value at the next rising clock edge and not before.
- R2: A set-only bit resets to 0. On a write its new value is the old value ORed with the written bit, so writing 0 never clears it.
- R3: A bit built as tied-0 always reads 0, and a bit built as tied-1 always reads 1. Writes and PMP reset do not change either.
- R4: If the bypass bit is 0 while `any_lock_i` is high, writes to the bypass bit are ignored. This freeze persists after `any_lock_i` falls, until a PMP reset.
- R5: A one-cycle `pmp_rst_i` pulse returns every field to its reset value at the next edge and lifts the bypass freeze.
- R6: Bits 3 and above always read 0. Writes to them are discarded.
- R7: When XLEN is 32, address 0x757 is claimed (`csr_hit_o` high), reads 0, and writes to it change nothing. Any other address other than 0x747 is not claimed, reads 0, and its writes are ignored.
- R8: A writable bypass bit can be set and cleared freely while it is not frozen. It can be cleared even while `any_lock_i` is high, provided it was 1. When the build switch makes it read-only, it reads 0.
- R9: `lockdown_o`, `allowlist_o` and `bypass_o` always equal the stored fields shown in the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pmp_rst_i | input | 1 | Synchronous PMP reset |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| csr_hit_o | output | 1 | Address belongs to this register |
| any_lock_i | input | 1 | Some PMP entry has its lock bit set |
| lockdown_o | output | 1 | Lockdown control bit |
| allowlist_o | output | 1 | Allowlist-policy control bit |
| bypass_o | output | 1 | Rule-lock bypass control bit |

## Verification
The bench writes 0 over set bits. A design that stores the write data directly would drop lockdown or allowlist here. It clears the bypass bit while a lock is present, then lowers the lock input and retries the set. A design that only gates on the live lock input would re-enable the bypass. It also writes all-ones to the upper alias and to reserved bits, where a loose decoder would leak data into the fields. A second instance built with tied fields shows that writes and PMP reset cannot move them.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;
  typedef enum logic [1:0] {
    BIT_RO0    = 2'd0,
    BIT_RO1    = 2'd1,
    BIT_STICKY = 2'd2
  } bit_mode_e;

  localparam int unsigned FIELD_W   = 3;
  localparam int unsigned IDX_LOCK  = 0;
  localparam int unsigned IDX_ALLOW = 1;
  localparam int unsigned IDX_BYP   = 2;
endpackage

// File: rtl/sec_cfg_sticky_bit.sv
module sec_cfg_sticky_bit #(
  parameter sec_cfg_pkg::bit_mode_e MODE = sec_cfg_pkg::BIT_STICKY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  localparam logic RST_VAL = (MODE == sec_cfg_pkg::BIT_RO1);

  logic q_q, nxt;

  generate
    if (MODE == sec_cfg_pkg::BIT_STICKY) begin : g_sticky
      assign nxt = q_q | set_i;
    end else begin : g_tied
      logic unused_set;
      assign unused_set = set_i;
      assign nxt        = RST_VAL;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= RST_VAL;
    else if (clr_i) q_q <= RST_VAL;
    else            q_q <= nxt;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sec_cfg_bypass_bit.sv
module sec_cfg_bypass_bit #(
  parameter bit WRITABLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic we_i,
  input  logic wd_i,
  input  logic any_lock_i,
  output logic q_o
);
  logic q_q, freeze_q, lock_now, blocked, nxt;

  generate
    if (WRITABLE) begin : g_rw
      assign nxt = wd_i;
    end else begin : g_ro
      logic unused_wd;
      assign unused_wd = wd_i;
      assign nxt       = 1'b0;
    end
  endgenerate

  // a clear bit meeting a lock freezes until PMP reset
  assign lock_now = ~q_q & any_lock_i;
  assign blocked  = freeze_q | lock_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q      <= 1'b0;
      freeze_q <= 1'b0;
    end else if (clr_i) begin
      q_q      <= 1'b0;
      freeze_q <= 1'b0;
    end else begin
      if (lock_now)            freeze_q <= 1'b1;
      if (we_i && !blocked)    q_q      <= nxt;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/sec_cfg_decode.sv
module sec_cfg_decode #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] ADDR_LO = 12'h747,
  parameter logic [ADDR_W-1:0] ADDR_HI = 12'h757
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            we_i,
  input  logic [sec_cfg_pkg::FIELD_W-1:0] fields_i,
  output logic                            lo_we_o,
  output logic                            hit_o,
  output logic [XLEN-1:0]                 rdata_o
);
  localparam bit HAS_HI = (XLEN == 32);

  logic lo_match, hi_match;

  assign lo_match = (addr_i == ADDR_LO);
  assign hi_match = HAS_HI && (addr_i == ADDR_HI);
  assign hit_o    = lo_match | hi_match;
  assign lo_we_o  = we_i & lo_match;

  always_comb begin
    rdata_o = '0;
    if (lo_match) rdata_o[sec_cfg_pkg::FIELD_W-1:0] = fields_i;
  end
endmodule

// File: rtl/sec_cfg_csr.sv
module sec_cfg_csr #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_LO = 12'h747,
  parameter logic [ADDR_W-1:0] ADDR_HI = 12'h757,
  parameter sec_cfg_pkg::bit_mode_e LOCKDOWN_MODE = sec_cfg_pkg::BIT_STICKY,
  parameter sec_cfg_pkg::bit_mode_e ALLOW_MODE    = sec_cfg_pkg::BIT_STICKY,
  parameter bit BYPASS_WRITABLE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pmp_rst_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_hit_o,
  input  logic            any_lock_i,
  output logic            lockdown_o,
  output logic            allowlist_o,
  output logic            bypass_o
);
  import sec_cfg_pkg::*;

  logic               lo_we;
  logic [FIELD_W-1:0] fields;
  logic               unused_rsvd;

  // reserved write bits are dropped
  assign unused_rsvd = ^csr_wdata_i[XLEN-1:FIELD_W];

  sec_cfg_decode #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_dec (
    .addr_i  (csr_addr_i),
    .we_i    (csr_we_i),
    .fields_i(fields),
    .lo_we_o (lo_we),
    .hit_o   (csr_hit_o),
    .rdata_o (csr_rdata_o)
  );

  sec_cfg_sticky_bit #(.MODE(LOCKDOWN_MODE)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (pmp_rst_i),
    .set_i (lo_we & csr_wdata_i[IDX_LOCK]),
    .q_o   (fields[IDX_LOCK])
  );

  sec_cfg_sticky_bit #(.MODE(ALLOW_MODE)) u_allow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (pmp_rst_i),
    .set_i (lo_we & csr_wdata_i[IDX_ALLOW]),
    .q_o   (fields[IDX_ALLOW])
  );

  sec_cfg_bypass_bit #(.WRITABLE(BYPASS_WRITABLE)) u_byp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (pmp_rst_i),
    .we_i      (lo_we),
    .wd_i      (csr_wdata_i[IDX_BYP]),
    .any_lock_i(any_lock_i),
    .q_o       (fields[IDX_BYP])
  );

  assign lockdown_o  = fields[IDX_LOCK];
  assign allowlist_o = fields[IDX_ALLOW];
  assign bypass_o    = fields[IDX_BYP];
endmodule

// File: rtl/sec_cfg_csr_chk.sv
module sec_cfg_csr_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_LO = 12'h747,
  parameter sec_cfg_pkg::bit_mode_e LOCKDOWN_MODE = sec_cfg_pkg::BIT_STICKY,
  parameter sec_cfg_pkg::bit_mode_e ALLOW_MODE    = sec_cfg_pkg::BIT_STICKY
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pmp_rst_i,
  input logic [ADDR_W-1:0] csr_addr_i,
  input logic            csr_we_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            any_lock_i,
  input logic            lockdown_o,
  input logic            allowlist_o,
  input logic            bypass_o
);
  localparam logic LOCK_RST  = (LOCKDOWN_MODE == sec_cfg_pkg::BIT_RO1);
  localparam logic ALLOW_RST = (ALLOW_MODE == sec_cfg_pkg::BIT_RO1);

  AST_READ_MATCHES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == ADDR_LO) |-> (csr_rdata_o[2:0] == {bypass_o, allowlist_o, lockdown_o})); // R9

  AST_LOCK_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockdown_o && !pmp_rst_i) |=> lockdown_o); // R2

  AST_ALLOW_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allowlist_o && !pmp_rst_i) |=> allowlist_o); // R2

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rdata_o[XLEN-1:3] == '0); // R6

  AST_BYPASS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_o && any_lock_i && !pmp_rst_i) |=> !bypass_o); // R4

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && !pmp_rst_i) |=> $stable({lockdown_o, allowlist_o, bypass_o})); // R1

  AST_PMP_RST_VALUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmp_rst_i |=> (!bypass_o && lockdown_o == LOCK_RST && allowlist_o == ALLOW_RST)); // R5
endmodule

bind sec_cfg_csr sec_cfg_csr_chk #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO),
  .LOCKDOWN_MODE(LOCKDOWN_MODE), .ALLOW_MODE(ALLOW_MODE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pmp_rst_i  (pmp_rst_i),
  .csr_addr_i (csr_addr_i),
  .csr_we_i   (csr_we_i),
  .csr_rdata_o(csr_rdata_o),
  .any_lock_i (any_lock_i),
  .lockdown_o (lockdown_o),
  .allowlist_o(allowlist_o),
  .bypass_o   (bypass_o)
);

// File: tb/sec_cfg_csr_tb_top.sv
module sec_cfg_csr_tb_top;
  localparam logic [11:0] A_LO = 12'h747;
  localparam logic [11:0] A_HI = 12'h757;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pmp_rst = 1'b0;
  logic [11:0] addr = A_LO;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        any_lock = 1'b0;
  logic [31:0] rdata, rdata_ro;
  logic        hit, hit_ro;
  logic        lock_o, allow_o, byp_o;
  logic        lock_ro, allow_ro, byp_ro;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sec_cfg_csr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pmp_rst_i(pmp_rst),
    .csr_addr_i(addr), .csr_we_i(we), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .csr_hit_o(hit), .any_lock_i(any_lock),
    .lockdown_o(lock_o), .allowlist_o(allow_o), .bypass_o(byp_o)
  );

  sec_cfg_csr #(
    .LOCKDOWN_MODE(sec_cfg_pkg::BIT_RO1),
    .ALLOW_MODE(sec_cfg_pkg::BIT_RO0),
    .BYPASS_WRITABLE(1'b0)
  ) dut_ro_i (
    .clk_i(clk), .rst_ni(rst_n), .pmp_rst_i(pmp_rst),
    .csr_addr_i(addr), .csr_we_i(we), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata_ro), .csr_hit_o(hit_ro), .any_lock_i(any_lock),
    .lockdown_o(lock_ro), .allowlist_o(allow_ro), .bypass_o(byp_ro)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = A_LO;
    #1;
  endtask

  task automatic pmp_reset();
    @(negedge clk);
    pmp_rst = 1'b1;
    @(negedge clk);
    pmp_rst = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    addr = A_LO; #1;
    chk("R1 reset read", rdata, 32'h0);
    chk("R9 reset outputs", {29'd0, byp_o, allow_o, lock_o}, 32'h0);
    chk("R3 tied-1 reset read", rdata_ro, 32'h1);
  endtask

  task automatic t_sticky();
    @(negedge clk);
    addr = A_LO; wdata = 32'h1; we = 1'b1;
    #1;
    chk("R1 no change before edge", rdata, 32'h0);
    @(negedge clk);
    we = 1'b0; #1;
    chk("R1 lockdown at bit0", rdata, 32'h1);
    chk("R9 lockdown_o", {31'd0, lock_o}, 32'h1);
    wr(A_LO, 32'h0);
    chk("R2 write 0 keeps bit", rdata, 32'h1);
    wr(A_LO, 32'h2);
    chk("R2 OR of allowlist", rdata, 32'h3);
    chk("R9 allowlist_o", {31'd0, allow_o}, 32'h1);
  endtask

  task automatic t_reserved();
    wr(A_LO, 32'hFFFF_FFF8);
    chk("R6 reserved write discarded", rdata, 32'h3);
  endtask

  task automatic t_bypass();
    any_lock = 1'b0;
    wr(A_LO, 32'h4);
    chk("R8 bypass set", rdata, 32'h7);
    chk("R9 bypass_o", {31'd0, byp_o}, 32'h1);
    any_lock = 1'b1;
    wr(A_LO, 32'h0);
    chk("R8 bypass clear under lock", {31'd0, byp_o}, 32'h0);
    wr(A_LO, 32'h4);
    chk("R4 set blocked under lock", {31'd0, byp_o}, 32'h0);
    any_lock = 1'b0;
    wr(A_LO, 32'h4);
    chk("R4 freeze persists", rdata, 32'h3);
  endtask

  task automatic t_pmp_reset();
    pmp_reset();
    chk("R5 sticky bits cleared", rdata, 32'h0);
    chk("R3 tied-1 survives pmp reset", rdata_ro, 32'h1);
    wr(A_LO, 32'h4);
    chk("R5 freeze lifted", rdata, 32'h4);
    wr(A_LO, 32'h0);
    chk("R8 bypass clear", rdata, 32'h0);
  endtask

  task automatic t_alias();
    wr(A_LO, 32'h1);
    @(negedge clk);
    addr = A_HI; #1;
    chk("R7 alias claimed", {31'd0, hit}, 32'h1);
    chk("R7 alias reads 0", rdata, 32'h0);
    wr(A_HI, 32'hFFFF_FFFF);
    chk("R7 alias write no effect", rdata, 32'h1);
    @(negedge clk);
    addr = 12'h748; #1;
    chk("R7 other addr unclaimed", {31'd0, hit}, 32'h0);
    chk("R7 other addr reads 0", rdata, 32'h0);
    wr(12'h748, 32'h6);
    chk("R7 other addr write ignored", rdata, 32'h1);
  endtask

  task automatic t_tied();
    wr(A_LO, 32'h6);
    chk("R3 tied fields ignore writes", rdata_ro, 32'h1);
    chk("R3 tied outputs", {29'd0, byp_ro, allow_ro, lock_ro}, 32'h1);
    wr(A_LO, 32'h0);
    chk("R3 tied-1 ignores zero write", rdata_ro, 32'h1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_reserved();
    t_bypass();
    t_pmp_reset();
    t_alias();
    t_tied();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule